// File: doc/BRIEF.md
# Playback Byte Counter and Interrupt Controller

This block sits between a playback channel's configuration registers and its DMA engine. It owns the DMA request line. It counts every byte that the DMA side reports as delivered. When a programmed block of audio frames has gone out, it raises the playback interrupt. The terminal byte count is the 16-bit frame count, taken from an upper and a lower count byte, multiplied by the bytes per frame of the current sample format. The format multiplier is given as a left shift.

Software starts playback by setting the enable input. The request then rises, and the byte counter begins from zero. While interrupts are enabled, the counter restarts by itself at every terminal count, so blocks follow one another with no software action. Software can acknowledge the interrupt in two ways: a write to the status port, or a write that clears the playback flag. An unusable format configuration releases the request.

Top module: `pbk_dma_irq_ctl`

## Requirements
- R1: After reset, `dma_req`, `irq`, `int_status` and `play_flag` are all 0.
- R2: When `dma_req` is 0 and a cycle samples `play_en`=1, `pio_mode`=0 and `fmt_ok`=1, `dma_req` is 1 from the next cycle. The byte counter restarts from zero at that point.
- R3: While `pio_mode` is 1, a request that is not running is not started. A request that is already running is left as it is.
- R4: A cycle that samples `play_en`=0 or `fmt_ok`=0 drops `dma_req` in the next cycle.
- R5: A byte is counted only in a cycle where both `byte_tick` and `dma_req` are 1. Ticks while the request is low are ignored.
- R6: The terminal count is `{cnt_hi,cnt_lo} << frame_shift`, with `frame_shift` in 0..3. A result of 0 is treated as 1.
- R7: With `irq_en`=1, the counted tick that brings the count to the terminal value (or past it) is the last byte of the block. In the next cycle `irq`, `int_status` and `play_flag` are 1, and the following block counts from the next tick.
- R8: With `irq_en`=0, no terminal event occurs, and counting continues and wraps at the counter width.
- R9: A cycle with `stat_wr`=1 clears `irq`, `int_status` and `play_flag`.
- R10: A cycle with `flag_wr`=1 loads `play_flag` with `flag_wdata`. If `flag_wdata`=0 while `play_flag` is 1, `irq` and `int_status` are also cleared. If `flag_wdata`=1, `irq` and `int_status` are left unchanged.
- R11: A terminal event takes priority over either clear path in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| play_en | input | 1 | Playback enable bit |
| pio_mode | input | 1 | Programmed-I/O mode bit; blocks starting the request |
| irq_en | input | 1 | Interrupt enable; gates count limiting |
| fmt_ok | input | 1 | Format configuration is valid and supported |
| cnt_hi | input | 8 | Upper byte of the frame count |
| cnt_lo | input | 8 | Lower byte of the frame count |
| frame_shift | input | 2 | Bytes-per-frame as a left shift |
| byte_tick | input | 1 | One byte delivered by the DMA side |
| stat_wr | input | 1 | Write strobe of the status port |
| flag_wr | input | 1 | Write strobe of the flag register |
| flag_wdata | input | 1 | Value written to the playback flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt line |
| int_status | output | 1 | Interrupt status bit |
| play_flag | output | 1 | Playback interrupt flag |

## Verification
The hardest situation to reach is a terminal byte tick that lands in the same cycle as an acknowledgement. It needs the bench to know the exact tick count of the block, so that a status or flag write can be placed on that very cycle. The stimulus programs small terminal counts with every shift value, including the zero count. It runs a fixed number of ticks and then aims the clear at the final tick. A long random phase follows. It mixes ticks, enables, format drops and clears against a behavioural model, so that a re-enable with a stale count above the terminal value also occurs.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

    localparam int FRAME_BITS = 16;
    localparam int SHIFT_W    = 2;
    localparam int MAX_SHIFT  = (1 << SHIFT_W) - 1;
    localparam int CNT_W      = FRAME_BITS + MAX_SHIFT;

    typedef logic [CNT_W-1:0] byte_cnt_t;

    typedef struct packed {
        logic play_en;
        logic pio_mode;
        logic irq_en;
        logic fmt_ok;
    } pbk_cfg_t;

    typedef struct packed {
        logic hit;
        logic counted;
    } cnt_evt_t;

    typedef struct packed {
        logic stat_wr;
        logic flag_wr;
        logic flag_wdata;
    } clr_req_t;

    function automatic byte_cnt_t term_bytes(input logic [FRAME_BITS-1:0] frames,
                                             input logic [SHIFT_W-1:0] shift);
        byte_cnt_t t;
        t = byte_cnt_t'(frames) << shift;
        if (t == '0) begin
            t = byte_cnt_t'(1);
        end
        return t;
    endfunction

endpackage

// File: rtl/pbk_run_ctl.sv
module pbk_run_ctl
    import pbk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pbk_cfg_t cfg,
    output logic     run,
    output logic     start
);

    logic run_q;
    logic run_d;

    always_comb begin
        start = !run_q && cfg.play_en && !cfg.pio_mode && cfg.fmt_ok;
        run_d = run_q;
        if (!cfg.fmt_ok || !cfg.play_en) begin
            run_d = 1'b0;
        end else if (start) begin
            run_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run = run_q;

    AST_FMT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !cfg.fmt_ok |=> !run_q); // R4
    AST_PIO_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!run_q && cfg.pio_mode) |=> !run_q); // R3

endmodule

// File: rtl/pbk_byte_cnt.sv
module pbk_byte_cnt
    import pbk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  start,
    input  logic                  irq_en,
    input  logic                  byte_tick,
    input  logic [FRAME_BITS-1:0] frames,
    input  logic [SHIFT_W-1:0]    shift,
    output cnt_evt_t              evt
);

    localparam byte_cnt_t ONE = byte_cnt_t'(1);

    byte_cnt_t cnt_q;
    byte_cnt_t cnt_inc;
    byte_cnt_t term;

    always_comb begin
        term        = term_bytes(frames, shift);
        cnt_inc     = cnt_q + ONE;
        evt.counted = run && byte_tick;
        evt.hit     = evt.counted && irq_en && (cnt_inc >= term);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start || evt.hit) begin
            cnt_q <= '0;
        end else if (evt.counted) begin
            cnt_q <= cnt_inc;
        end
    end

    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == '0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt_q)); // R5
    AST_HIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/pbk_irq_ctl.sv
module pbk_irq_ctl
    import pbk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  clr_req_t clr,
    output logic     pend,
    output logic     flag
);

    logic pend_q;
    logic flag_q;
    logic flag_ack;

    always_comb begin
        flag_ack = clr.flag_wr && !clr.flag_wdata && flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (hit) begin
                pend_q <= 1'b1;
            end else if (clr.stat_wr || flag_ack) begin
                pend_q <= 1'b0;
            end
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clr.stat_wr) begin
                flag_q <= 1'b0;
            end else if (clr.flag_wr) begin
                flag_q <= clr.flag_wdata;
            end
        end
    end

    assign pend = pend_q;
    assign flag = flag_q;

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
        hit |=> (pend_q && flag_q)); // R7
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr.stat_wr && !hit) |=> (!pend_q && !flag_q)); // R9
    AST_FLAG_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (clr.flag_wr && clr.flag_wdata && !clr.stat_wr && !hit) |=> $stable(pend_q)); // R10

endmodule

// File: rtl/pbk_dma_irq_ctl.sv
module pbk_dma_irq_ctl
    import pbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       play_en,
    input  logic       pio_mode,
    input  logic       irq_en,
    input  logic       fmt_ok,
    input  logic [7:0] cnt_hi,
    input  logic [7:0] cnt_lo,
    input  logic [1:0] frame_shift,
    input  logic       byte_tick,
    input  logic       stat_wr,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    output logic       dma_req,
    output logic       irq,
    output logic       int_status,
    output logic       play_flag
);

    pbk_cfg_t cfg;
    clr_req_t clr;
    cnt_evt_t evt;
    logic     run;
    logic     start;
    logic     pend;

    assign cfg = '{play_en: play_en, pio_mode: pio_mode, irq_en: irq_en, fmt_ok: fmt_ok};
    assign clr = '{stat_wr: stat_wr, flag_wr: flag_wr, flag_wdata: flag_wdata};

    pbk_run_ctl u_run (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .run   (run),
        .start (start)
    );

    pbk_byte_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .start     (start),
        .irq_en    (irq_en),
        .byte_tick (byte_tick),
        .frames    ({cnt_hi, cnt_lo}),
        .shift     (frame_shift),
        .evt       (evt)
    );

    pbk_irq_ctl u_irq (
        .clk  (clk),
        .rst  (rst),
        .hit  (evt.hit),
        .clr  (clr),
        .pend (pend),
        .flag (play_flag)
    );

    assign dma_req    = run;
    assign irq        = pend;
    assign int_status = pend;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!dma_req && !irq && !play_flag)); // R1
    AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> !evt.hit); // R5
    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!irq_en && !irq && !stat_wr) |=> !irq); // R8

endmodule

// File: tb/sim_pbk_dma_irq_ctl.sv
module sim_pbk_dma_irq_ctl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic play_en = 0, pio_mode = 0, irq_en = 0, fmt_ok = 1;
    logic [7:0] cnt_hi = 0, cnt_lo = 0;
    logic [1:0] frame_shift = 0;
    logic byte_tick = 0, stat_wr = 0, flag_wr = 0, flag_wdata = 0;
    logic dma_req, irq, int_status, play_flag;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string tag = "R1";

    int  m_cnt = 0;
    bit  m_run = 0, m_pend = 0, m_flag = 0;
    bit  m_hit_last = 0;
    bit  compare_on = 0;

    always #5 clk = ~clk;

    pbk_dma_irq_ctl u0 (
        .clk(clk), .rst(rst), .play_en(play_en), .pio_mode(pio_mode),
        .irq_en(irq_en), .fmt_ok(fmt_ok), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .frame_shift(frame_shift), .byte_tick(byte_tick), .stat_wr(stat_wr),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .dma_req(dma_req),
        .irq(irq), .int_status(int_status), .play_flag(play_flag)
    );

    // Behavioural reference, updated on every rising edge.
    always @(posedge clk) begin
        int  term;
        bit  start, counted, hit, ack;
        if (rst) begin
            m_cnt = 0; m_run = 0; m_pend = 0; m_flag = 0; m_hit_last = 0;
        end else begin
            term = (cnt_hi * 256 + cnt_lo) << frame_shift;
            if (term == 0) term = 1;
            start   = !m_run && play_en && !pio_mode && fmt_ok;
            counted = m_run && byte_tick;
            hit     = counted && irq_en && (m_cnt + 1 >= term);
            ack     = flag_wr && !flag_wdata && m_flag;
            if (start || hit) m_cnt = 0;
            else if (counted) m_cnt = (m_cnt + 1) % 524288;
            if (hit) m_pend = 1;
            else if (stat_wr || ack) m_pend = 0;
            if (hit) m_flag = 1;
            else if (stat_wr) m_flag = 0;
            else if (flag_wr) m_flag = flag_wdata;
            if (!fmt_ok || !play_en) m_run = 0;
            else if (start) m_run = 1;
            m_hit_last = hit;
        end
    end

    task automatic chk(input string name, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            chk("dma_req", dma_req, m_run);
            chk("irq", irq, m_pend);
            chk("int_status", int_status, m_pend);
            chk("play_flag", play_flag, m_flag);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            byte_tick = 1; step(1);
        end
        byte_tick = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        compare_on = 1;
        step(1);
        tag = "R1";
        chk("reset irq", irq, 1'b0);
        chk("reset req", dma_req, 1'b0);

        // R5: ticks before start are ignored
        tag = "R5"; irq_en = 1; cnt_lo = 2; ticks(5);
        chk("no flag idle", play_flag, 1'b0);

        // R2: start, block of 2 frames * 2 bytes (R6)
        tag = "R2"; frame_shift = 1; play_en = 1; step(1);
        chk("req up", dma_req, 1'b1);
        tag = "R6"; ticks(3);
        chk("not yet", irq, 1'b0);
        tag = "R7"; ticks(1);
        chk("irq at terminal", irq, 1'b1);
        tag = "R9"; stat_wr = 1; step(1); stat_wr = 0;
        chk("status clears", irq, 1'b0);
        chk("status clears flag", play_flag, 1'b0);
        tag = "R7"; ticks(4);
        chk("auto restart", irq, 1'b1);

        // R10: flag write paths
        tag = "R10"; flag_wr = 1; flag_wdata = 0; step(1); flag_wr = 0;
        chk("flag ack", irq, 1'b0);
        flag_wr = 1; flag_wdata = 1; step(1); flag_wr = 0;
        chk("flag set only", play_flag, 1'b1);
        chk("no irq from set", irq, 1'b0);
        stat_wr = 1; step(1); stat_wr = 0;

        // R11: clear on the terminal tick
        tag = "R11"; ticks(3); byte_tick = 1; stat_wr = 1; step(1);
        byte_tick = 0; stat_wr = 0;
        chk("hit beats clear", irq, 1'b1);
        ticks(3); byte_tick = 1; flag_wr = 1; flag_wdata = 0; step(1);
        byte_tick = 0; flag_wr = 0;
        chk("hit beats flag ack", irq, 1'b1);
        stat_wr = 1; step(1); stat_wr = 0;

        // R6: zero count means one byte per block, every shift
        tag = "R6";
        for (int s = 0; s < 4; s++) begin
            frame_shift = s[1:0]; cnt_lo = 0; cnt_hi = 0;
            ticks(1);
            chk("zero count", irq, 1'b1);
            stat_wr = 1; step(1); stat_wr = 0;
        end
        cnt_lo = 1; frame_shift = 3; ticks(7);
        chk("shift3 short", irq, 1'b0);
        ticks(1);
        chk("shift3 end", irq, 1'b1);
        stat_wr = 1; step(1); stat_wr = 0;

        // R8: no interrupt when disabled
        tag = "R8"; irq_en = 0; ticks(40);
        chk("no irq disabled", irq, 1'b0);
        tag = "R7"; irq_en = 1; ticks(1);
        chk("stale count fires", irq, 1'b1);
        stat_wr = 1; step(1); stat_wr = 0;

        // R4 and R3
        tag = "R4"; fmt_ok = 0; step(1);
        chk("fmt release", dma_req, 1'b0);
        fmt_ok = 1; pio_mode = 1; step(2);
        tag = "R3"; chk("pio blocks start", dma_req, 1'b0);
        pio_mode = 0; step(1);
        chk("start after pio", dma_req, 1'b1);
        pio_mode = 1; step(2);
        chk("pio keeps running", dma_req, 1'b1);
        pio_mode = 0;
        tag = "R4"; play_en = 0; step(1);
        chk("disable release", dma_req, 1'b0);

        // Random mix compared against the model
        tag = "R7";
        for (int i = 0; i < 20000; i++) begin
            int r = $urandom_range(0, 99);
            byte_tick  = (r < 60);
            stat_wr    = ($urandom_range(0, 40) == 0);
            flag_wr    = ($urandom_range(0, 40) == 0);
            flag_wdata = $urandom_range(0, 1);
            if ($urandom_range(0, 200) == 0) play_en = ~play_en;
            if ($urandom_range(0, 300) == 0) pio_mode = ~pio_mode;
            if ($urandom_range(0, 400) == 0) fmt_ok = ~fmt_ok;
            if ($urandom_range(0, 300) == 0) irq_en = ~irq_en;
            if ($urandom_range(0, 200) == 0) begin
                cnt_lo = $urandom_range(0, 12);
                frame_shift = $urandom_range(0, 3);
            end
            if (!play_en && $urandom_range(0, 20) == 0) play_en = 1;
            if (!fmt_ok && $urandom_range(0, 20) == 0) fmt_ok = 1;
            step(1);
        end
        byte_tick = 0; stat_wr = 0; flag_wr = 0;
        step(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule